// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a 16-bit count as a low byte and a high byte. It advances either on ticks of a shared clock prescaler or on falling edges of its own external pin. A per-channel mode field changes the shape of the count path while the block runs. The shapes are a 13-bit counter, a 16-bit counter, and an 8-bit counter that reloads from the high byte. A fourth shape exists on channel 0 only: its two bytes become independent free-running 8-bit counters.

Software drives the block through a small register port. Writes take effect at a clock edge, and read data is combinational from the address. There are six registers: control, mode and the four count bytes. Every wrap of a counter sets a sticky overflow flag, and the flags are also driven onto two output pins for an interrupt controller outside the block.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all six registers read 0. Channels are stopped, both modes are 13-bit timer mode, and the prescaler divides by 12.
- R2: In timer mode a running channel advances once per prescaler tick. Control bit 4 picks the divisor: 0 divides by 12 and 1 divides by 4. Every write to control restarts the prescaler, so the first advance lands exactly one divisor period of clocks after that write.
- R3: With the mode bit "external" set (bit 2 for channel 0, bit 6 for channel 1), a running channel advances once for each 1-to-0 transition of its pin (`ext_pin[0]` or `ext_pin[1]`), seen through a two-flop synchronizer. Rising edges and held levels do not advance it, and neither do prescaler ticks.
- R4: Mode 0 (13-bit): bits 4:0 of the low byte carry into the high byte. Bits 7:5 of the low byte stay unchanged. The value 0x1FFF wraps to 0 and sets the channel's flag.
- R5: Mode 1 (16-bit): {high, low} advances by one. 0xFFFF wraps to 0x0000 and sets the flag.
- R6: Mode 2 (8-bit reload): the low byte advances. At 0xFF it is loaded from the high byte and the flag is set. The high byte never changes.
- R7: Mode 3 on channel 0 (split): the low byte is an 8-bit counter that uses run0, the channel 0 source and flag0. The high byte counts prescaler ticks gated by run1, and its wrap sets flag1. While split is active, channel 1 still counts, but its own wraps do not set flag1.
- R8: Mode 3 on channel 1 freezes channel 1's count, whatever the state of run1.
- R9: A flag (control bit 1 for channel 0, bit 3 for channel 1) stays set until a control write puts 0 in that bit. Writing 1 there leaves it unchanged. Flags appear on `ovf_o[1:0]`.
- R10: A channel whose run bit (control bit 0 or bit 2) is 0 holds its count.
- R11: Register map by address: 0 control {presel, flag1, run1, flag0, run0} in bits 4:0; 1 mode {ch1 cfg in 6:4, ch0 cfg in 2:0}, where each cfg is {external, mode[1:0]} and bits 7 and 3 read 0; 2 and 3 are channel 0 low and high; 4 and 5 are channel 1 low and high. A byte write in the same cycle as an advance wins for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ext_pin | input | 2 | External count inputs, one per channel |
| ovf_o | output | 2 | Sticky overflow flags {ch1, ch0} |

## Verification
The bench keeps the default parameters: a slow divisor of 12, a fast divisor of 4 and a two-stage synchronizer. Because the prescaler restarts on every control write, the fast divisor lets a preloaded count cross its wrap point within a dozen clocks. That puts every mode's boundary within reach of a short run. The slow divisor is checked at the exact clock where its first advance lands, so a wrong divisor or an off-by-one terminal count shows up as a miscount.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int PRE13_W = 5;

    typedef enum logic [1:0] {
        MD_13    = 2'd0,
        MD_16    = 2'd1,
        MD_RLD   = 2'd2,
        MD_SPLIT = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   ext_sel;
        tmode_e mode;
    } chcfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        logic presel;
        logic ovf1;
        logic run1;
        logic ovf0;
        logic run0;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_C0L  = 3'd2;
    localparam logic [ADDR_W-1:0] A_C0H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_C1L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_C1H  = 3'd5;

endpackage

// File: rtl/tmr_pair_presc.sv
module tmr_pair_presc #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim   = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
        tick  = (cnt_q >= lim);
        cnt_d = cnt_q + PW'(1);
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tmr_pair_edge.sv
module tmr_pair_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = (sync_q << 1) | STAGES'(pin);
        prev_d = sync_q[STAGES-1];
        fall   = prev_q & ~sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/tmr_pair_step.sv
module tmr_pair_step
    import tmr_pair_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0
) (
    input  cnt_t   cur,
    input  tmode_e mode,
    input  logic   inc,
    input  logic   inc_hi,
    output cnt_t   nxt,
    output logic   ovf,
    output logic   ovf_hi
);
    localparam int W13 = BYTE_W + PRE13_W;
    localparam int W16 = 2 * BYTE_W;

    logic [W13-1:0] v13, v13_inc;
    logic [W16-1:0] v16_inc;

    always_comb begin
        nxt     = cur;
        ovf     = 1'b0;
        ovf_hi  = 1'b0;
        v13     = {cur.hi, cur.lo[PRE13_W-1:0]};
        v13_inc = v13 + W13'(1);
        v16_inc = cur + W16'(1);
        case (mode)
            MD_13: begin
                if (inc) begin
                    ovf                   = &v13;
                    nxt.hi                = v13_inc[W13-1:PRE13_W];
                    nxt.lo[PRE13_W-1:0]   = v13_inc[PRE13_W-1:0];
                end
            end
            MD_16: begin
                if (inc) begin
                    ovf = &cur;
                    nxt = cnt_t'(v16_inc);
                end
            end
            MD_RLD: begin
                if (inc) begin
                    if (&cur.lo) begin
                        nxt.lo = cur.hi;
                        ovf    = 1'b1;
                    end else begin
                        nxt.lo = cur.lo + BYTE_W'(1);
                    end
                end
            end
            MD_SPLIT: begin
                if (SPLIT_OK) begin
                    if (inc) begin
                        ovf    = &cur.lo;
                        nxt.lo = cur.lo + BYTE_W'(1);
                    end
                    if (inc_hi) begin
                        ovf_hi = &cur.hi;
                        nxt.hi = cur.hi + BYTE_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [1:0]        ext_pin,
    output logic [1:0]        ovf_o
);
    localparam int NCH = 2;

    typedef struct packed {
        ctrl_t                ctrl;
        chcfg_t [NCH-1:0]     cfg;
        cnt_t   [NCH-1:0]     cnt;
    } st_t;

    st_t st_d, st_q;

    logic             tick;
    logic             wr_ctrl;
    logic             split;
    logic [NCH-1:0]   fall;
    logic [NCH-1:0]   run_v;
    logic [NCH-1:0]   inc;
    logic [NCH-1:0]   inc_hi;
    logic [NCH-1:0]   ovf_w;
    logic [NCH-1:0]   ovf_hi_w;
    cnt_t [NCH-1:0]   nxt;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign split   = (st_q.cfg[0].mode == MD_SPLIT);
    assign run_v   = {st_q.ctrl.run1, st_q.ctrl.run0};

    tmr_pair_presc #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .fast    (st_q.ctrl.presel),
        .tick    (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_pair_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[g]),
            .fall  (fall[g])
        );

        assign inc[g]    = run_v[g] & (st_q.cfg[g].ext_sel ? fall[g] : tick);
        assign inc_hi[g] = (g == 0) ? (st_q.ctrl.run1 & tick) : 1'b0;

        tmr_pair_step #(
            .SPLIT_OK (g == 0)
        ) u_step (
            .cur    (st_q.cnt[g]),
            .mode   (st_q.cfg[g].mode),
            .inc    (inc[g]),
            .inc_hi (inc_hi[g]),
            .nxt    (nxt[g]),
            .ovf    (ovf_w[g]),
            .ovf_hi (ovf_hi_w[g])
        );
    end

    always_comb begin
        logic set0, set1, keep0, keep1;
        st_d        = st_q;
        st_d.cnt[0] = nxt[0];
        st_d.cnt[1] = nxt[1];

        set0  = ovf_w[0];
        set1  = split ? ovf_hi_w[0] : (ovf_w[1] | ovf_hi_w[1]);
        keep0 = wr_ctrl ? wdata[1] : 1'b1;
        keep1 = wr_ctrl ? wdata[3] : 1'b1;
        st_d.ctrl.ovf0 = set0 | (st_q.ctrl.ovf0 & keep0);
        st_d.ctrl.ovf1 = set1 | (st_q.ctrl.ovf1 & keep1);

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    st_d.ctrl.run0   = wdata[0];
                    st_d.ctrl.run1   = wdata[2];
                    st_d.ctrl.presel = wdata[4];
                end
                A_MODE: begin
                    st_d.cfg[0] = chcfg_t'(wdata[2:0]);
                    st_d.cfg[1] = chcfg_t'(wdata[6:4]);
                end
                A_C0L:   st_d.cnt[0].lo = wdata;
                A_C0H:   st_d.cnt[0].hi = wdata;
                A_C1L:   st_d.cnt[1].lo = wdata;
                A_C1H:   st_d.cnt[1].hi = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {3'b000, st_q.ctrl};
            A_MODE:  rdata = {1'b0, st_q.cfg[1], 1'b0, st_q.cfg[0]};
            A_C0L:   rdata = st_q.cnt[0].lo;
            A_C0H:   rdata = st_q.cnt[0].hi;
            A_C1L:   rdata = st_q.cnt[1].lo;
            A_C1H:   rdata = st_q.cnt[1].hi;
            default: rdata = '0;
        endcase
    end

    assign ovf_o = {st_q.ctrl.ovf1, st_q.ctrl.ovf0};
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pair_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata,
    input logic [1:0]        ovf,
    input logic              run0,
    input logic [1:0]        mode0,
    input logic [1:0]        mode1,
    input logic              ext0,
    input logic              tick,
    input logic [15:0]       c0,
    input logic [15:0]       c1
);
    AST_OVF0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] && !(wr_en && addr == A_CTRL && !wdata[1]) |=> ovf[0]); // R9
    AST_OVF1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[1] && !(wr_en && addr == A_CTRL && !wdata[3]) |=> ovf[1]); // R9
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !run0 && !wr_en |=> $stable(c0[7:0])); // R10
    AST_CH1_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        mode1 == 2'd3 && !wr_en |=> $stable(c1)); // R8
    AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (!rst_n)
        mode0 == 2'd2 && !ext0 && run0 && tick && c0[7:0] == 8'hFF && !wr_en
        |=> (c0[7:0] == $past(c0[15:8])) && $stable(c0[15:8])); // R6
    AST_UPPER3_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mode0 == 2'd0 && !wr_en |=> $stable(c0[7:5])); // R4
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .ovf   (ovf_o),
    .run0  (st_q.ctrl.run0),
    .mode0 (st_q.cfg[0].mode),
    .mode1 (st_q.cfg[1].mode),
    .ext0  (st_q.cfg[0].ext_sel),
    .tick  (tick),
    .c0    (st_q.cnt[0]),
    .c1    (st_q.cnt[1])
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
    import tmr_pair_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] ext_pin = 2'b11;
    logic [1:0] ovf_o;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    tmr_pair u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .ext_pin (ext_pin),
        .ovf_o   (ovf_o)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [1:0] mode;
        logic       sel;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] n;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic       eflag;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},
        '{2'd0, 1'b1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'hE1, 1'b1},
        '{2'd0, 1'b0, 8'h12, 8'h1F, 8'd1, 8'h13, 8'h00, 1'b0},
        '{2'd2, 1'b1, 8'hF0, 8'hFE, 8'd3, 8'hF0, 8'hF1, 1'b1},
        '{2'd1, 1'b0, 8'h00, 8'hFF, 8'd2, 8'h01, 8'h01, 1'b0},
        '{2'd3, 1'b1, 8'h55, 8'hFE, 8'd2, 8'h55, 8'h00, 1'b1}
    };

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'd0:    return "R4";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 6; a++) begin
            rdchk(3'(a), 8'h00, "R1");
        end

        // Table walk over modes and divisors (R2 via advance counts)
        for (int i = 0; i < NV; i++) begin
            int div;
            int k;
            div = VEC[i].sel ? 4 : 12;
            k   = int'(VEC[i].n) * div + div / 2;
            wr(A_CTRL, 8'h00);
            wr(A_MODE, {6'b0, VEC[i].mode});
            wr(A_C0H, VEC[i].hi);
            wr(A_C0L, VEC[i].lo);
            wr(A_CTRL, {3'b000, VEC[i].sel, 3'b000, 1'b1});
            wait_n(k);
            wr(A_CTRL, {3'b000, VEC[i].sel, 1'b1, 1'b0, 1'b1, 1'b0});
            rdchk(A_C0H, VEC[i].ehi, tag_of(VEC[i].mode));
            rdchk(A_C0L, VEC[i].elo, tag_of(VEC[i].mode));
            rdchk(A_CTRL, {3'b000, VEC[i].sel, 2'b00, VEC[i].eflag, 1'b0}, tag_of(VEC[i].mode));
        end

        // R2: exact landing of first advance, slow then fast divisor
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h01);
        wr(A_C0H, 8'h00);
        wr(A_C0L, 8'h00);
        wr(A_CTRL, 8'h01);
        wait_n(11);
        rdchk(A_C0L, 8'h00, "R2");
        rdchk(A_C0L, 8'h01, "R2");
        wr(A_CTRL, 8'h11);
        wait_n(3);
        rdchk(A_C0L, 8'h01, "R2");
        rdchk(A_C0L, 8'h02, "R2");

        // R11: byte write beats a simultaneous advance
        wr(A_CTRL, 8'h00);
        wr(A_C0L, 8'h00);
        wr(A_CTRL, 8'h11);
        wait_n(7);
        wr(A_C0L, 8'h40);
        wr(A_CTRL, 8'h1A);
        rdchk(A_C0L, 8'h40, "R11");
        rdchk(A_C0H, 8'h00, "R11");

        // R10: stopped channel holds
        wait_n(30);
        rdchk(A_C0L, 8'h40, "R10");

        // R11: mode register readback, unused bits read 0
        wr(A_MODE, 8'hFF);
        rdchk(A_MODE, 8'h77, "R11");

        // R8: channel 1 in mode 3 is frozen
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h30);
        wr(A_C1L, 8'h77);
        wr(A_C1H, 8'h66);
        wr(A_CTRL, 8'h14);
        wait_n(30);
        rdchk(A_C1L, 8'h77, "R8");
        rdchk(A_C1H, 8'h66, "R8");

        // R3: external falling edges on channel 1
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h50);
        wr(A_C1L, 8'h00);
        wr(A_C1H, 8'h00);
        wr(A_CTRL, 8'h14);
        for (int p = 0; p < 3; p++) begin
            ext_pin[1] = 1'b0;
            wait_n(4);
            ext_pin[1] = 1'b1;
            wait_n(4);
        end
        wait_n(6);
        wr(A_CTRL, 8'h10);
        rdchk(A_C1L, 8'h03, "R3");
        rdchk(A_C1H, 8'h00, "R3");
        rdchk(A_C0L, 8'h40, "R10");

        // R7: split mode, channel 1 wrap does not raise flag1
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h13);
        wr(A_C0H, 8'h10);
        wr(A_C0L, 8'h00);
        wr(A_C1L, 8'hFF);
        wr(A_C1H, 8'hFF);
        wr(A_CTRL, 8'h14);
        wait_n(6);
        wr(A_CTRL, 8'h1A);
        rdchk(A_C1L, 8'h00, "R7");
        rdchk(A_C1H, 8'h00, "R7");
        rdchk(A_C0H, 8'h11, "R7");
        rdchk(A_C0L, 8'h00, "R7");
        rdchk(A_CTRL, 8'h10, "R7");
        // R7: split high byte wrap raises flag1
        wr(A_C0H, 8'hFF);
        wr(A_CTRL, 8'h14);
        wait_n(6);
        wr(A_CTRL, 8'h1A);
        rdchk(A_C0H, 8'h00, "R7");
        rdchk(A_CTRL, 8'h18, "R7");

        // R9: flag kept by writing 1, cleared by writing 0
        wr(A_CTRL, 8'h1A);
        rdchk(A_CTRL, 8'h18, "R9");
        wait_n(10);
        chk("R9", {6'b0, ovf_o}, 8'h02);
        wr(A_CTRL, 8'h10);
        rdchk(A_CTRL, 8'h10, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule